// File: doc/BRIEF.md
# Parallel EEPROM Page Writer with Completion Polling

This block sits on the host side of an asynchronous byte-wide EEPROM bus. On a start request it loads between one and a full page of bytes into the device with self-paced write strobes, then keeps reading the device until its internal programming cycle has finished. It reports the result as a one-cycle done pulse, or as a one-cycle timeout pulse when the device never reports completion.

All strobe timing is counted in clock cycles: address and data setup, write pulse width, recovery between strobes, and read access time are parameters. Two ways of detecting completion are offered and chosen per operation by `mode_i`. In data polling the last written address is read back until bit 7 matches the bit 7 that was written. In toggle polling the device is read repeatedly until bit 6 holds the same value on two reads in a row, which needs no record of what was written.

Write data is pulled from the user side by index: the block presents `byte_idx_o` and takes `byte_i` as the byte at that page offset, in the same cycle.

Top module: `eep_wr_poller`

## Requirements
- R1: After reset, `ce_no`, `we_no` and `oe_no` are high, `dq_oe_o` is low, and `busy_o`, `done_o` and `timeout_o` are low.
- R2: `we_no` is low only while `ce_no` is low, `oe_no` is high and `dq_oe_o` is high.
- R3: One operation writes exactly `len_m1_i`+1 bytes. Byte k goes to address {`page_i`, k} for k from 0 upward, with the data that `byte_i` held while `byte_idx_o` was k. The upper address bits (page, bits 15..7) stay fixed for the whole operation.
- R4: Consecutive falling edges of `we_no` within one page load are exactly SETUP_CYC+PULSE_CYC+HOLD_CYC cycles apart, and always less than LOAD_WIN_CYC cycles apart.
- R5: During a read, `dq_oe_o` is low and `we_no` is high. Each read holds `ce_no` and `oe_no` low for exactly ACC_CYC cycles, and both return high to end it.
- R6: With `mode_i`=0 (data polling), every read uses the last written address. The operation completes on the first read whose bit 7 equals bit 7 of the last written byte.
- R7: With `mode_i`=1 (toggle polling), the operation completes on the first read whose bit 6 equals bit 6 of the read just before it. The first read never completes.
- R8: If MAX_POLLS reads pass without completion, `timeout_o` pulses instead of `done_o`, and no further read is made. Completion seen on read number MAX_POLLS gives `done_o`.
- R9: `done_o` and `timeout_o` are one-cycle pulses and never high together. `busy_o` is high from the cycle after a start is accepted and falls in the cycle where the ending pulse is high.
- R10: A `start_i` pulse that arrives while `busy_o` is high is ignored: it starts no further writes and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| mode_i | input | 1 | Completion method: 0 bit-7 data polling, 1 bit-6 toggle polling |
| page_i | input | 9 | Page number, placed on address bits 15..7 |
| len_m1_i | input | 7 | Number of bytes to write minus one |
| byte_i | input | 8 | Write byte at offset `byte_idx_o` |
| byte_idx_o | output | 7 | Page offset of the byte wanted on `byte_i` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: programming completed |
| timeout_o | output | 1 | One-cycle pulse: poll limit reached |
| ce_no | output | 1 | Device chip enable, active low |
| we_no | output | 1 | Device write enable, active low |
| oe_no | output | 1 | Device output enable, active low |
| addr_o | output | 16 | Device address |
| dq_o | output | 8 | Write data towards the device |
| dq_oe_o | output | 1 | Host drives the data bus when high |
| dq_i | input | 8 | Data read from the device |

## Verification
The coincidence that matters is completion and the poll limit falling on the same read: the sample that ends the final permitted read can both match and exhaust the count. The bench's device model keeps the part busy for a chosen number of reads, so that the first good read is exactly read MAX_POLLS, in both modes. It expects `done_o` with no `timeout_o` there, and `timeout_o` with exactly MAX_POLLS reads counted on `oe_no` when the busy period is one read longer.

// File: rtl/eep_poll_pkg.sv
`timescale 1ns/1ps
package eep_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RSET,
    ST_RACC,
    ST_RREC
  } st_e;
endpackage

// File: rtl/eep_phase_timer.sv
`timescale 1ns/1ps
module eep_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eep_cmpl_judge.sv
`timescale 1ns/1ps
module eep_cmpl_judge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic smp_i,
  input  logic mode_i,
  input  logic ref_b7_i,
  input  logic rd_b7_i,
  input  logic rd_b6_i,
  output logic hit_o
);
  logic have_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (clr_i) begin
      have_q <= 1'b0;
    end else if (smp_i) begin
      have_q <= 1'b1;
      prev_q <= rd_b6_i;
    end
  end

  // mode 0: bit 7 matches written data; mode 1: bit 6 stable over two reads
  assign hit_o = mode_i ? (have_q && (rd_b6_i == prev_q)) : (rd_b7_i == ref_b7_i);
endmodule

// File: rtl/eep_strobe_dec.sv
`timescale 1ns/1ps
module eep_strobe_dec
  import eep_poll_pkg::*;
(
  input  st_e  st_i,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic dq_oe_o
);
  always_comb begin
    ce_no   = 1'b1;
    we_no   = 1'b1;
    oe_no   = 1'b1;
    dq_oe_o = 1'b0;
    unique case (st_i)
      ST_WSET: begin ce_no = 1'b0; dq_oe_o = 1'b1; end
      ST_WPUL: begin ce_no = 1'b0; we_no = 1'b0; dq_oe_o = 1'b1; end
      ST_WHLD: dq_oe_o = 1'b1;
      ST_RACC: begin ce_no = 1'b0; oe_no = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/eep_wr_poller.sv
`timescale 1ns/1ps
module eep_wr_poller
  import eep_poll_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 128,
  parameter int SETUP_CYC    = 2,
  parameter int PULSE_CYC    = 5,
  parameter int HOLD_CYC     = 2,
  parameter int ACC_CYC      = 5,
  parameter int LOAD_WIN_CYC = 5000,
  parameter int MAX_POLLS    = 4000,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int PG_W        = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [OFF_W-1:0]  len_m1_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [OFF_W-1:0]  byte_idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              ce_no,
  output logic              we_no,
  output logic              oe_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int M1   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2   = (HOLD_CYC > ACC_CYC) ? HOLD_CYC : ACC_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int PW   = $clog2(MAX_POLLS + 1);
  localparam logic [OFF_W-1:0] OFF_ONE  = OFF_W'(1);
  localparam logic [PW-1:0]    POLL_END = PW'(MAX_POLLS - 1);

  st_e st_q, st_d;
  logic              mode_q;
  logic [OFF_W-1:0]  len_q, off_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q;
  logic [PW-1:0]     poll_q;
  logic              done_q, to_q;

  logic          tm_load, tm_zero;
  logic [TW-1:0] tm_val;
  logic ld_first, ld_next, rd_clr, rd_smp, poll_inc, fin_done, fin_to, hit;
  logic unused_dq;

  assign unused_dq = ^dq_i;

  eep_phase_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tm_load),
    .val_i  (tm_val),
    .zero_o (tm_zero)
  );

  eep_cmpl_judge u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rd_clr),
    .smp_i    (rd_smp),
    .mode_i   (mode_q),
    .ref_b7_i (dq_q[POLL_BIT]),
    .rd_b7_i  (dq_i[POLL_BIT]),
    .rd_b6_i  (dq_i[TOG_BIT]),
    .hit_o    (hit)
  );

  eep_strobe_dec u_dec (
    .st_i    (st_q),
    .ce_no   (ce_no),
    .we_no   (we_no),
    .oe_no   (oe_no),
    .dq_oe_o (dq_oe_o)
  );

  always_comb begin
    st_d     = st_q;
    tm_load  = 1'b0;
    tm_val   = '0;
    ld_first = 1'b0;
    ld_next  = 1'b0;
    rd_clr   = 1'b0;
    rd_smp   = 1'b0;
    poll_inc = 1'b0;
    fin_done = 1'b0;
    fin_to   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_WSET; tm_load = 1'b1; tm_val = TW'(SETUP_CYC - 1); ld_first = 1'b1;
      end
      ST_WSET: if (tm_zero) begin
        st_d = ST_WPUL; tm_load = 1'b1; tm_val = TW'(PULSE_CYC - 1);
      end
      ST_WPUL: if (tm_zero) begin
        st_d = ST_WHLD; tm_load = 1'b1; tm_val = TW'(HOLD_CYC - 1);
      end
      ST_WHLD: if (tm_zero) begin
        tm_load = 1'b1; tm_val = TW'(SETUP_CYC - 1);
        if (off_q == len_q) st_d = ST_RSET;
        else begin st_d = ST_WSET; ld_next = 1'b1; end
      end
      ST_RSET: if (tm_zero) begin
        st_d = ST_RACC; tm_load = 1'b1; tm_val = TW'(ACC_CYC - 1); rd_clr = 1'b1;
      end
      ST_RACC: if (tm_zero) begin
        rd_smp = 1'b1;
        if (hit) begin
          st_d = ST_IDLE; fin_done = 1'b1;
        end else if (poll_q == POLL_END) begin
          st_d = ST_IDLE; fin_to = 1'b1;
        end else begin
          st_d = ST_RREC; tm_load = 1'b1; tm_val = TW'(HOLD_CYC - 1); poll_inc = 1'b1;
        end
      end
      ST_RREC: if (tm_zero) begin
        st_d = ST_RACC; tm_load = 1'b1; tm_val = TW'(ACC_CYC - 1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      len_q  <= '0;
      off_q  <= '0;
      addr_q <= '0;
      dq_q   <= '0;
      poll_q <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_done;
      to_q   <= fin_to;
      if (ld_first) begin
        mode_q <= mode_i;
        len_q  <= len_m1_i;
        off_q  <= '0;
        addr_q <= {page_i, {OFF_W{1'b0}}};
        dq_q   <= byte_i;
        poll_q <= '0;
      end
      if (ld_next) begin
        off_q              <= off_q + OFF_ONE;
        addr_q[OFF_W-1:0]  <= off_q + OFF_ONE;
        dq_q               <= byte_i;
      end
      if (poll_inc) poll_q <= poll_q + 1'b1;
    end
  end

  assign byte_idx_o = (st_q == ST_IDLE) ? '0 : off_q + OFF_ONE;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = to_q;
  assign addr_o     = addr_q;
  assign dq_o       = dq_q;
endmodule

// File: rtl/eep_wr_poller_chk.sv
`timescale 1ns/1ps
module eep_wr_poller_chk #(
  parameter int ADDR_W       = 16,
  parameter int OFF_W        = 7,
  parameter int LOAD_WIN_CYC = 5000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              ce_no,
  input logic              we_no,
  input logic              oe_no,
  input logic              dq_oe_o,
  input logic [ADDR_W-1:0] addr_o
);
  logic        we_prev_q, in_load_q;
  logic [31:0] gap_q;
  logic        we_fall;

  assign we_fall = we_prev_q && !we_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_prev_q <= 1'b1;
      in_load_q <= 1'b0;
      gap_q     <= '0;
    end else begin
      we_prev_q <= we_no;
      if (!oe_no || !busy_o) begin
        in_load_q <= 1'b0;
        gap_q     <= '0;
      end else if (we_fall) begin
        in_load_q <= 1'b1;
        gap_q     <= 32'd1;
      end else if (in_load_q && gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  a_r2_we_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (!ce_no && oe_no && dq_oe_o));

  a_r5_bus_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (!dq_oe_o && we_no && !ce_no));

  a_r4_load_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_fall && in_load_q) |-> (gap_q < LOAD_WIN_CYC));

  a_r3_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o[ADDR_W-1:OFF_W]));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_to_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  a_r9_end_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || timeout_o));
endmodule

bind eep_wr_poller eep_wr_poller_chk #(
  .ADDR_W       (ADDR_W),
  .OFF_W        (OFF_W),
  .LOAD_WIN_CYC (LOAD_WIN_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .timeout_o (timeout_o),
  .ce_no     (ce_no),
  .we_no     (we_no),
  .oe_no     (oe_no),
  .dq_oe_o   (dq_oe_o),
  .addr_o    (addr_o)
);

// File: tb/eep_wr_poller_tb.sv
`timescale 1ns/1ps
module eep_wr_poller_tb;
  localparam int SETUP = 2, PULSE = 3, HOLD = 2, ACC = 3, WIN = 20, MAXP = 8;
  localparam int PER = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0;
  logic [8:0] page_i = '0;
  logic [6:0] len_m1_i = '0;
  logic [7:0] byte_i;
  logic [6:0] byte_idx_o;
  logic busy_o, done_o, timeout_o, ce_no, we_no, oe_no, dq_oe_o;
  logic [15:0] addr_o;
  logic [7:0] dq_o, dq_i;

  always #(PER/2) clk_i = ~clk_i;

  eep_wr_poller #(
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD), .ACC_CYC(ACC),
    .LOAD_WIN_CYC(WIN), .MAX_POLLS(MAXP)
  ) u_dut (.*);

  int tests = 0, fails = 0;
  logic [7:0] buf_q [128];
  assign byte_i = buf_q[byte_idx_o];

  // device model
  int rd_n = 0, wr_n = 0, k_busy = 0;
  bit sb = 0, md_cur = 0, gap_bad = 0, oe_bad = 0, ra_bad = 0, st_bad = 0;
  logic [7:0] last_wr = '0;
  logic [15:0] wa [128];
  logic [7:0] wd [128];
  logic [15:0] exp_last;
  time t_wf = 0, t_of = 0;

  always @(negedge we_no) begin
    if (wr_n > 0 && ($time - t_wf) != (SETUP + PULSE + HOLD) * PER) gap_bad = 1;
    if (ce_no !== 1'b0 || oe_no !== 1'b1 || dq_oe_o !== 1'b1) st_bad = 1;
    t_wf = $time;
  end
  always @(posedge we_no) if (rst_ni) begin
    if (wr_n < 128) begin wa[wr_n] = addr_o; wd[wr_n] = dq_o; end
    last_wr = dq_o;
    wr_n++;
  end
  always @(negedge oe_no) begin
    rd_n++;
    t_of = $time;
    if (dq_oe_o !== 1'b0 || we_no !== 1'b1) oe_bad = 1;
    if (!md_cur && addr_o !== exp_last) ra_bad = 1;
  end
  always @(posedge oe_no) if (rst_ni && ($time - t_of) != ACC * PER) oe_bad = 1;

  always @* begin
    if (rd_n <= k_busy) dq_i = {~last_wr[7], rd_n[0] ^ sb, last_wr[5:0]};
    else                dq_i = last_wr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reads needed until completion, from the model's busy behaviour
  function automatic int exp_reads(bit md, int k, bit s, bit t6);
    if (!md) return k + 1;
    for (int j = 2; j <= k + 2; j++) begin
      bit a, b;
      a = (j - 1 <= k) ? ((j - 1) % 2 == 1) ^ s : t6;
      b = (j <= k) ? (j % 2 == 1) ^ s : t6;
      if (a == b) return j;
    end
    return k + 2;
  endfunction

  task automatic run_op(input logic [8:0] pg, input logic [6:0] len, input bit md,
                        input int k, input bit s, input bit poke);
    int n, exp_rd, cyc, bad;
    bit exp_to, got_done, got_to;
    for (int i = 0; i < 128; i++) buf_q[i] = 8'($urandom);
    k_busy = k; sb = s; rd_n = 0; wr_n = 0; md_cur = md;
    gap_bad = 0; oe_bad = 0; ra_bad = 0; st_bad = 0;
    exp_last = {pg, len};
    @(negedge clk_i);
    start_i = 1'b1; page_i = pg; len_m1_i = len; mode_i = md;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R9 busy after start", busy_o, 1);
    if (poke) begin
      repeat (4) @(negedge clk_i);
      start_i = 1'b1; page_i = ~pg; len_m1_i = 7'd0; mode_i = ~md;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!(done_o || timeout_o) && cyc < 6000) begin @(negedge clk_i); cyc++; end
    got_done = done_o; got_to = timeout_o;
    n = exp_reads(md, k, s, buf_q[len][6]);
    exp_to = (n > MAXP);
    exp_rd = exp_to ? MAXP : n;
    chk(wr_n == int'(len) + 1, "R3 byte count", wr_n, int'(len) + 1);
    bad = 0;
    for (int i = 0; i <= int'(len) && i < 128; i++)
      if (wa[i] !== {pg, 7'(i)} || wd[i] !== buf_q[i]) bad++;
    chk(bad == 0, "R3 address/data per byte", bad, 0);
    chk(!st_bad, "R2 write strobe qualifiers", st_bad, 0);
    chk(!gap_bad, "R4 WE fall spacing", gap_bad, 0);
    chk(!oe_bad, "R5 read strobe shape", oe_bad, 0);
    if (!md) chk(!ra_bad, "R6 poll address is last written", ra_bad, 0);
    chk(got_done == !exp_to, md ? "R7 done" : "R6 done", got_done, !exp_to);
    chk(got_to == exp_to, "R8 timeout flag", got_to, exp_to);
    chk(rd_n == exp_rd, "R8 read count", rd_n, exp_rd);
    @(negedge clk_i);
    chk(!done_o && !timeout_o && !busy_o, "R9 single-cycle end", {done_o, timeout_o, busy_o}, 0);
    if (poke) begin
      repeat (20) @(negedge clk_i);
      chk(wr_n == int'(len) + 1 && !busy_o, "R10 start while busy ignored", wr_n, int'(len) + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) buf_q[i] = '0;
    repeat (3) @(negedge clk_i);
    chk(ce_no === 1'b1 && we_no === 1'b1 && oe_no === 1'b1 && dq_oe_o === 1'b0,
        "R1 strobes idle in reset", {ce_no, we_no, oe_no, dq_oe_o}, 4'b1110);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !timeout_o, "R1 flags idle", {busy_o, done_o, timeout_o}, 0);

    run_op(9'h001, 7'd0,   1'b0, 0, 1'b0, 1'b0);  // R6 one byte, ready at once
    run_op(9'h1ff, 7'd127, 1'b0, 3, 1'b0, 1'b0);  // R3 full page
    run_op(9'h0a5, 7'd5,   1'b1, 0, 1'b1, 1'b0);  // R7 needs two reads
    run_op(9'h03c, 7'd9,   1'b1, 4, 1'b0, 1'b0);  // R7 busy toggling
    run_op(9'h100, 7'd2,   1'b0, MAXP - 1, 1'b0, 1'b0); // R8 good on last read
    run_op(9'h101, 7'd2,   1'b0, MAXP, 1'b0, 1'b0);     // R8 one read short
    run_op(9'h102, 7'd3,   1'b1, 20, 1'b1, 1'b0);       // R8 toggle timeout
    run_op(9'h055, 7'd30,  1'b0, 2, 1'b0, 1'b1);        // R10 poke start
    run_op(9'h0aa, 7'd1,   1'b1, 3, 1'b0, 1'b1);        // R10 poke start
    for (int r = 0; r < 20; r++)
      run_op(9'($urandom), 7'($urandom_range(127, 0)), 1'($urandom),
             int'($urandom_range(MAXP + 1, 0)), 1'($urandom), 1'($urandom_range(3, 0) == 0));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule